// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles branches while they sit in the Decode stage of a five-stage in-order pipeline. Each cycle it gets the decoded instruction's branch kind, its incremented PC, a word offset and the two register operands read in Decode. It computes the branch target with an adder of its own, because the fetch incrementer is busy every cycle. It tests the two operands for equality with a comparator of its own. Then it chooses the PC that Fetch uses next. Because the outcome is known one stage after fetch, a taken branch costs at most one fetch slot.

Two branch kinds are supported: an unconditional jump, and a branch taken only when the two operands are equal. A mode input picks how the slot after a branch is handled. In delayed mode the instruction already fetched behind the branch always completes, so nothing is flushed. In non-delayed mode a taken branch also raises a flush that turns the Fetch/Decode buffer into a NOP. A conditional branch that is not taken keeps that instruction. All outputs are registered and change on the clock edge that ends the branch's Decode cycle.

Top module: `br_resolve_top`

## Requirements
- R1: While reset is asserted and after it is released with no decoded instruction, `next_pc_o` equals parameter RESET_PC (0 by default), and `redirect_o` and `fd_flush_o` are 0.
- R2: The branch target is `dec_pc_plus_i` plus the sign-extended `dec_offset_i` multiplied by four (instruction size in bytes), so negative offsets branch backward.
- R3: A valid instruction of kind 2'b01 (jump) is always taken: on the next clock edge `next_pc_o` becomes the target and `redirect_o` is 1.
- R4: A valid instruction of kind 2'b10 (branch-if-equal) is taken exactly when `dec_opnd_a_i` equals `dec_opnd_b_i` in all bits.
- R5: When no branch is taken, `next_pc_o` takes `seq_pc_i` on the next edge and `redirect_o` is 0.
- R6: Kind 2'b00 (no branch), kind 2'b11 (reserved) and any kind with `dec_valid_i` low have no effect: the outputs behave as a not-taken cycle.
- R7: Outputs are due one clock edge after the Decode inputs are presented. `redirect_o` is high for exactly one cycle per taken branch, and back-to-back taken branches each redirect.
- R8: With `delay_mode_i` = 1 (delayed branching), `fd_flush_o` is never asserted.
- R9: With `delay_mode_i` = 0, `fd_flush_o` is 1 in the same cycle as `redirect_o` for every taken branch, and stays 0 for a not-taken conditional branch.
- R10: The target addition wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| dec_kind_i | input | 2 | Branch kind: 00 none, 01 jump, 10 branch-if-equal, 11 reserved |
| dec_pc_plus_i | input | ADDR_W | Incremented PC of the instruction in Decode |
| dec_offset_i | input | OFS_W | Signed word offset of the branch |
| dec_opnd_a_i | input | DATA_W | First register operand read in Decode |
| dec_opnd_b_i | input | DATA_W | Second register operand read in Decode |
| seq_pc_i | input | ADDR_W | Sequential next PC from the fetch incrementer |
| delay_mode_i | input | 1 | 1 = delayed branching, 0 = flush on taken branch |
| next_pc_o | output | ADDR_W | PC for Fetch to use next |
| redirect_o | output | 1 | Pulses when a taken branch steers Fetch |
| fd_flush_o | output | 1 | Turn the Fetch/Decode buffer into a NOP |

## Verification
Every result comes from one register stage. A branch presented before an edge shows its next PC, redirect and flush values on that same edge. The driver queues the expected triple as it drives the inputs ahead of the edge. The monitor samples a short time after that edge and compares against the head of the queue, so every comparison lands exactly one cycle after its stimulus. Reset values are checked with no item queued.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_JUMP = 2'b01,
    BK_BEQ  = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;
endpackage

// File: rtl/br_tgt_add.sv
module br_tgt_add #(
  parameter int ADDR_W      = 32,
  parameter int OFS_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_plus_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int SHIFT = $clog2(INSTR_BYTES);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] ofs_bytes;

  always_comb begin
    ofs_ext   = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};
    ofs_bytes = ofs_ext << SHIFT;
    target_o  = pc_plus_i + ofs_bytes;
  end
endmodule

// File: rtl/br_eq_cmp.sv
module br_eq_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              eq_o
);
  logic [DATA_W-1:0] bit_same;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign bit_same[g] = ~(a_i[g] ^ b_i[g]);
  end

  assign eq_o = &bit_same;
endmodule

// File: rtl/br_next_sel.sv
module br_next_sel
  import br_resolve_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  br_kind_e          kind_i,
  input  logic              eq_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic              delay_mode_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              redirect_o,
  output logic              flush_o
);
  logic              taken;
  logic [ADDR_W-1:0] pc_d, pc_q;
  logic              redir_d, redir_q;
  logic              flush_d, flush_q;
  logic              upd_en;

  always_comb begin
    taken = 1'b0;
    if (valid_i) begin
      unique case (kind_i)
        BK_JUMP: taken = 1'b1;
        BK_BEQ:  taken = eq_i;
        default: taken = 1'b0;
      endcase
    end
    pc_d    = taken ? target_i : seq_pc_i;
    redir_d = taken;
    flush_d = taken & ~delay_mode_i;
    upd_en  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      redir_q <= 1'b0;
      flush_q <= 1'b0;
    end else if (upd_en) begin
      pc_q    <= pc_d;
      redir_q <= redir_d;
      flush_q <= flush_d;
    end
  end

  assign next_pc_o  = pc_q;
  assign redirect_o = redir_q;
  assign flush_o    = flush_q;
endmodule

// File: rtl/br_resolve_top.sv
module br_resolve_top
  import br_resolve_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                OFS_W       = 16,
  parameter int                DATA_W      = 32,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [1:0]        dec_kind_i,
  input  logic [ADDR_W-1:0] dec_pc_plus_i,
  input  logic [OFS_W-1:0]  dec_offset_i,
  input  logic [DATA_W-1:0] dec_opnd_a_i,
  input  logic [DATA_W-1:0] dec_opnd_b_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic              delay_mode_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              redirect_o,
  output logic              fd_flush_o
);
  logic [ADDR_W-1:0] target;
  logic              opnd_eq;
  br_kind_e          kind;

  assign kind = br_kind_e'(dec_kind_i);

  br_tgt_add #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .INSTR_BYTES(INSTR_BYTES)
  ) i_tgt_add (
    .pc_plus_i(dec_pc_plus_i),
    .offset_i (dec_offset_i),
    .target_o (target)
  );

  br_eq_cmp #(.DATA_W(DATA_W)) i_eq_cmp (
    .a_i (dec_opnd_a_i),
    .b_i (dec_opnd_b_i),
    .eq_o(opnd_eq)
  );

  br_next_sel #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) i_next_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (dec_valid_i),
    .kind_i      (kind),
    .eq_i        (opnd_eq),
    .target_i    (target),
    .seq_pc_i    (seq_pc_i),
    .delay_mode_i(delay_mode_i),
    .next_pc_o   (next_pc_o),
    .redirect_o  (redirect_o),
    .flush_o     (fd_flush_o)
  );

  a_r3_jump_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_kind_i == 2'b01) |=> redirect_o);

  a_r4_beq_unequal_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_kind_i == 2'b10 && dec_opnd_a_i != dec_opnd_b_i) |=> !redirect_o);

  a_r5_idle_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> (!redirect_o && next_pc_o == $past(seq_pc_i)));

  a_r6_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_kind_i == 2'b11 || dec_kind_i == 2'b00) |=> !redirect_o);

  a_r8_no_flush_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_mode_i |=> !fd_flush_o);

  a_r9_flush_with_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_flush_o |-> redirect_o);
endmodule

// File: tb/test_br_resolve_top.sv
module test_br_resolve_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        dec_valid_i;
  logic [1:0]  dec_kind_i;
  logic [31:0] dec_pc_plus_i;
  logic [15:0] dec_offset_i;
  logic [31:0] dec_opnd_a_i;
  logic [31:0] dec_opnd_b_i;
  logic [31:0] seq_pc_i;
  logic        delay_mode_i;
  logic [31:0] next_pc_o;
  logic        redirect_o;
  logic        fd_flush_o;

  typedef struct {
    logic [31:0] pc;
    logic        redir;
    logic        flush;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #4 clk_i = ~clk_i;

  br_resolve_top i_br_resolve_top (.*);

  task automatic check(input string tag, input logic [31:0] pc, input logic rd,
                       input logic fl);
    n_cmp++;
    if (next_pc_o !== pc || redirect_o !== rd || fd_flush_o !== fl) begin
      n_bad++;
      $display("FAIL %s: got pc=%h redir=%b flush=%b, expected pc=%h redir=%b flush=%b",
               tag, next_pc_o, redirect_o, fd_flush_o, pc, rd, fl);
    end
  endtask

  // Driver: presents one Decode-stage instruction and queues its expected result.
  task automatic drive(input string tag, input logic v, input logic [1:0] k,
                       input logic [31:0] pcp, input logic [15:0] ofs,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] seq, input logic dm);
    exp_t        e;
    logic        tk;
    logic [31:0] tgt;
    tgt = pcp + ({{16{ofs[15]}}, ofs} * 32'd4);
    tk  = v && ((k == 2'b01) || (k == 2'b10 && a == b));
    e.pc    = tk ? tgt : seq;
    e.redir = tk;
    e.flush = tk && !dm;
    e.tag   = tag;
    dec_valid_i = v; dec_kind_i = k; dec_pc_plus_i = pcp; dec_offset_i = ofs;
    dec_opnd_a_i = a; dec_opnd_b_i = b; seq_pc_i = seq; delay_mode_i = dm;
    exp_q.push_back(e);
    @(negedge clk_i);
  endtask

  // Monitor: compares one cycle after each queued stimulus.
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, e.pc, e.redir, e.flush);
    end
  end

  initial begin
    rst_ni = 1'b0;
    dec_valid_i = 1'b0; dec_kind_i = 2'b00; dec_pc_plus_i = '0; dec_offset_i = '0;
    dec_opnd_a_i = '0; dec_opnd_b_i = '0; seq_pc_i = '0; delay_mode_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 32'h0, 1'b0, 1'b0);

    drive("R3 R2 R8 jump fwd delayed", 1, 2'b01, 32'h100, 16'd5, 0, 1, 32'h104, 1);
    drive("R5 idle", 0, 2'b00, 32'h0, 16'd0, 0, 0, 32'h118, 1);
    drive("R2 jump backward", 1, 2'b01, 32'h200, 16'hFFFD, 0, 0, 32'h204, 1);
    drive("R4 R9 beq equal flush", 1, 2'b10, 32'h300, 16'd8, 32'hDEAD, 32'hDEAD, 32'h304, 0);
    drive("R4 R9 beq unequal", 1, 2'b10, 32'h400, 16'd8, 32'h1, 32'h2, 32'h404, 0);
    drive("R4 beq msb differs", 1, 2'b10, 32'h500, 16'd8, 32'h8000_0000, 32'h0, 32'h504, 1);
    drive("R6 kind none", 1, 2'b00, 32'h600, 16'd9, 0, 0, 32'h604, 0);
    drive("R6 kind reserved", 1, 2'b11, 32'h700, 16'd9, 0, 0, 32'h704, 0);
    drive("R6 invalid jump", 0, 2'b01, 32'h800, 16'd9, 0, 0, 32'h804, 0);
    drive("R7 back-to-back 1", 1, 2'b01, 32'h900, 16'd1, 0, 0, 32'h904, 0);
    drive("R7 back-to-back 2", 1, 2'b01, 32'hA00, 16'd2, 0, 0, 32'hA04, 0);
    drive("R7 pulse ends", 0, 2'b00, 32'h0, 16'd0, 0, 0, 32'hA0C, 0);
    drive("R10 wrap", 1, 2'b01, 32'hFFFF_FFFC, 16'd2, 0, 0, 32'h0, 1);
    drive("R8 beq equal delayed", 1, 2'b10, 32'hB00, 16'hFFFF, 32'h5, 32'h5, 32'hB04, 1);
    drive("R5 drain", 0, 2'b00, 32'h0, 16'd0, 0, 0, 32'hC00, 1);
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule